// File: doc/BRIEF.md
# Key Event Queue with Autorepeat and Interrupt

This block sits behind a keypad scanner that has already debounced the switches. Each debounced change arrives as a one-cycle strobe with a 6-bit key index and a flag that tells a press from a release. The block stores these events in a small first-in first-out queue. The host drains the queue through a one-byte read port. Every byte it reads packs the key number, the press or release kind, and a flag that says whether more entries wait behind it. A few reserved key values stand for an empty queue, a lost-data marker and a repeat marker.

While at least one key stays held, the block can insert a shared repeat marker. The first marker comes after a programmable delay counted in debounce ticks, and later markers follow at a programmable interval. An active-low interrupt tells the host to come and read. It fires when the stored count reaches a programmable level, or a programmable number of debounce ticks after the newest entry, whichever happens first. It then clears either on any read or once the queue has drained, as selected.

Top module: `key_event_queue`

## Requirements
- R1: The queue holds 16 entries. Out of reset it is empty, `rd_data` shows 0x3F and `irq_n` is high.
- R2: A queued key event reads as {more, release, key}: bits 5:0 hold the key number, bit 6 is 1 for a release and 0 for a press, and bit 7 is 1 when another entry (or a pending overflow marker) remains after this one. Entries come out in the order they were accepted.
- R3: An empty queue reads as 0x3F. A read strobe on an empty queue with no pending overflow changes nothing, so the next accepted event is the next byte returned.
- R4: An event that arrives while all 16 slots are full and no read frees a slot is dropped, and a sticky overflow flag is set. Once the stored entries are drained, the next read returns 0x7F and clears the flag. Reads after that return 0x3F.
- R5: When `rel_en` is 0, release events are not queued. Press events are still queued.
- R6: With `rpt_en` high and `key_held` high, the first repeat marker is queued on the 8×(`rpt_delay_sel`+1)-th debounce tick after the last key event strobe. The marker reads as 0x3E when it is the last entry and 0x7E when more follow.
- R7: After the first marker, further markers are queued every 4×(`rpt_rate_sel`+1) debounce ticks. Only one marker is queued per interval, and the held key's own number is not queued again.
- R8: Any key event strobe (press or release, queued or filtered) restarts the repeat sequence from the first delay. A cycle with `key_held` low or `rpt_en` low also returns it to the start.
- R9: With `irq_time_sel` = t and t from 1 to 31, the interrupt asserts on the t-th debounce tick after the newest accepted entry. t = 0 disables this source.
- R10: With `irq_fill_sel` = f and f from 1 to 7, the interrupt asserts one cycle after the stored count reaches 2f+2. f = 0 disables this source.
- R11: With `irq_clr_on_read` = 1, any read strobe deasserts the interrupt at the clock edge that takes the read.
- R12: With `irq_clr_on_read` = 0, the interrupt stays asserted across reads and deasserts one cycle after the queue becomes empty with no pending overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Debounced key event strobe |
| evt_key | input | 6 | Key index of the event |
| evt_release | input | 1 | 1 = release event, 0 = press event |
| rel_en | input | 1 | Queue release events when 1 |
| db_tick | input | 1 | One pulse per debounce cycle |
| key_held | input | 1 | At least one key is currently down |
| rpt_en | input | 1 | Autorepeat enable |
| rpt_delay_sel | input | 4 | First repeat delay, 8×(n+1) ticks |
| rpt_rate_sel | input | 3 | Repeat interval, 4×(n+1) ticks |
| irq_time_sel | input | 5 | Tick-timer interrupt delay, 0 = off |
| irq_fill_sel | input | 3 | Fill-level interrupt threshold 2n+2, 0 = off |
| irq_clr_on_read | input | 1 | 1 = clear on any read, 0 = clear when empty |
| rd_stb | input | 1 | Host read strobe; pops the byte on rd_data |
| rd_data | output | 8 | Byte returned by a read in this cycle |
| irq_n | output | 1 | Active-low interrupt |

## Verification
`rd_data` is a combinational view of the queue head. An accepted event or a read therefore shows up on it just after the clock edge that takes the strobe. A repeat marker appears just after the edge of the debounce tick that completes its delay, and the tick-timer interrupt is due at the same edge relative to its own count. The fill-level interrupt comes one cycle after the edge that brings the count to the threshold. Clear-on-read takes effect at the read edge, and clear-on-empty one cycle after the draining edge. The bench drives every input on the falling clock edge and samples on the falling edge after the cycles counted above. It also checks the cycle just before each due point, so an early or late result is reported.

// File: rtl/keyq_pkg.sv
package keyq_pkg;
    localparam int KEY_W = 6;

    localparam logic [KEY_W-1:0] KEY_RPT = 6'd62;
    localparam logic [KEY_W-1:0] KEY_NIL = 6'd63;

    localparam logic [7:0] BYTE_EMPTY = 8'h3F;
    localparam logic [7:0] BYTE_OVF   = 8'h7F;

    typedef struct packed {
        logic             rpt;
        logic             rel;
        logic [KEY_W-1:0] key;
    } entry_t;
endpackage

// File: rtl/keyq_fifo.sv
module keyq_fifo
    import keyq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  entry_t        push_entry,
    input  logic          rd_stb,
    output logic          wr_ok,
    output logic [CW-1:0] count,
    output logic          ovf,
    output logic [7:0]    rd_byte
);
    typedef struct packed {
        entry_t [DEPTH-1:0] mem;
        logic [PW-1:0]      wp;
        logic [PW-1:0]      rp;
        logic [CW-1:0]      cnt;
        logic               ovf;
    } state_t;

    state_t st_d, st_q;
    logic   pop_ok, ovf_rd, full, more;
    entry_t head;

    function automatic logic [PW-1:0] inc_ptr(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d   = st_q;
        full   = (st_q.cnt == CW'(DEPTH));
        pop_ok = rd_stb && (st_q.cnt != '0);
        ovf_rd = rd_stb && (st_q.cnt == '0) && st_q.ovf;
        wr_ok  = push && (!full || pop_ok);

        if (wr_ok) begin
            st_d.mem[st_q.wp] = push_entry;
            st_d.wp           = inc_ptr(st_q.wp);
        end
        if (push && !wr_ok) begin
            st_d.ovf = 1'b1;
        end
        if (pop_ok) begin
            st_d.rp = inc_ptr(st_q.rp);
        end
        if (ovf_rd) begin
            st_d.ovf = 1'b0;
        end
        st_d.cnt = st_q.cnt + CW'(wr_ok) - CW'(pop_ok);

        head = st_q.mem[st_q.rp];
        more = (st_q.cnt > CW'(1)) || st_q.ovf;
        if (st_q.cnt == '0) begin
            rd_byte = st_q.ovf ? BYTE_OVF : BYTE_EMPTY;
        end else if (head.rpt) begin
            rd_byte = {1'b0, more, KEY_RPT};
        end else begin
            rd_byte = {more, head.rel, head.key};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;
    assign ovf   = st_q.ovf;
endmodule

// File: rtl/keyq_repeat.sv
module keyq_repeat #(
    parameter int DLY_W  = 4,
    parameter int RATE_W = 3,
    parameter int STEP_D = 8,
    parameter int STEP_R = 4,
    localparam int MAXD  = STEP_D * (1 << DLY_W),
    localparam int MAXR  = STEP_R * (1 << RATE_W),
    localparam int CNT_W = $clog2(((MAXD > MAXR) ? MAXD : MAXR) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              held,
    input  logic              en,
    input  logic              evt,
    input  logic [DLY_W-1:0]  dly_sel,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              rpt_push
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             in_rate;
    } state_t;

    state_t           st_d, st_q;
    logic [CNT_W-1:0] lim_first, lim_rate, limit;

    always_comb begin
        st_d      = st_q;
        rpt_push  = 1'b0;
        lim_first = CNT_W'(STEP_D) * (CNT_W'(dly_sel) + CNT_W'(1));
        lim_rate  = CNT_W'(STEP_R) * (CNT_W'(rate_sel) + CNT_W'(1));
        limit     = st_q.in_rate ? lim_rate : lim_first;

        if (evt || !held || !en) begin
            st_d = '0;
        end else if (tick) begin
            if (st_q.cnt + CNT_W'(1) == limit) begin
                rpt_push     = 1'b1;
                st_d.cnt     = '0;
                st_d.in_rate = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/keyq_irq.sv
module keyq_irq #(
    parameter int CW     = 5,
    parameter int TIME_W = 5,
    parameter int FILL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_ok,
    input  logic [CW-1:0]     count,
    input  logic              q_empty,
    input  logic              rd_stb,
    input  logic              clr_on_read,
    input  logic [TIME_W-1:0] time_sel,
    input  logic [FILL_W-1:0] fill_sel,
    output logic              irq
);
    typedef struct packed {
        logic              armed;
        logic [TIME_W-1:0] tcnt;
        logic              above;
        logic              irq;
    } state_t;

    state_t        st_d, st_q;
    logic [CW-1:0] thr;
    logic          above_now, fill_set, time_set, set, clr;

    always_comb begin
        st_d      = st_q;
        thr       = CW'({fill_sel, 1'b0}) + CW'(2);
        above_now = (fill_sel != '0) && (count >= thr);
        fill_set  = above_now && !st_q.above;
        time_set  = 1'b0;

        if (time_sel == '0) begin
            st_d.armed = 1'b0;
        end else if (wr_ok) begin
            st_d.armed = 1'b1;
            st_d.tcnt  = '0;
        end else if (st_q.armed && tick) begin
            if (st_q.tcnt + TIME_W'(1) == time_sel) begin
                time_set   = 1'b1;
                st_d.armed = 1'b0;
            end else begin
                st_d.tcnt = st_q.tcnt + TIME_W'(1);
            end
        end

        st_d.above = above_now;
        set        = fill_set || time_set;
        clr        = clr_on_read ? rd_stb : q_empty;
        if (clr_on_read) begin
            st_d.irq = set || (st_q.irq && !clr);
        end else begin
            st_d.irq = (set || st_q.irq) && !clr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.irq;
endmodule

// File: rtl/key_event_queue.sv
module key_event_queue
    import keyq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DLY_W  = 4,
    parameter int RATE_W = 3,
    parameter int TIME_W = 5,
    parameter int FILL_W = 3,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [KEY_W-1:0]  evt_key,
    input  logic              evt_release,
    input  logic              rel_en,
    input  logic              db_tick,
    input  logic              key_held,
    input  logic              rpt_en,
    input  logic [DLY_W-1:0]  rpt_delay_sel,
    input  logic [RATE_W-1:0] rpt_rate_sel,
    input  logic [TIME_W-1:0] irq_time_sel,
    input  logic [FILL_W-1:0] irq_fill_sel,
    input  logic              irq_clr_on_read,
    input  logic              rd_stb,
    output logic [7:0]        rd_data,
    output logic              irq_n
);
    logic          rpt_push, fifo_push, wr_ok, q_ovf, irq;
    logic [CW-1:0] q_count;
    entry_t        push_entry;

    keyq_repeat #(
        .DLY_W (DLY_W),
        .RATE_W(RATE_W)
    ) u_rpt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (db_tick),
        .held    (key_held),
        .en      (rpt_en),
        .evt     (evt_valid),
        .dly_sel (rpt_delay_sel),
        .rate_sel(rpt_rate_sel),
        .rpt_push(rpt_push)
    );

    always_comb begin
        fifo_push = (evt_valid && (rel_en || !evt_release)) || rpt_push;
        if (evt_valid) begin
            push_entry = '{rpt: 1'b0, rel: evt_release, key: evt_key};
        end else begin
            push_entry = '{rpt: 1'b1, rel: 1'b0, key: KEY_RPT};
        end
    end

    keyq_fifo #(
        .DEPTH(DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_push),
        .push_entry(push_entry),
        .rd_stb    (rd_stb),
        .wr_ok     (wr_ok),
        .count     (q_count),
        .ovf       (q_ovf),
        .rd_byte   (rd_data)
    );

    keyq_irq #(
        .CW    (CW),
        .TIME_W(TIME_W),
        .FILL_W(FILL_W)
    ) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (db_tick),
        .wr_ok      (wr_ok),
        .count      (q_count),
        .q_empty    ((q_count == '0) && !q_ovf),
        .rd_stb     (rd_stb),
        .clr_on_read(irq_clr_on_read),
        .time_sel   (irq_time_sel),
        .fill_sel   (irq_fill_sel),
        .irq        (irq)
    );

    assign irq_n = ~irq;
endmodule

// File: rtl/keyq_checker.sv
module keyq_checker #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] q_count,
    input logic          q_ovf,
    input logic [7:0]    rd_data,
    input logic          rd_stb,
    input logic          fifo_push,
    input logic          wr_ok,
    input logic          rpt_push,
    input logic          rpt_en,
    input logic          key_held,
    input logic          evt_valid
);
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CW'(DEPTH)); // R1

    AST_EMPTY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == '0 && !q_ovf) |-> rd_data == 8'h3F); // R3

    AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == '0 && !q_ovf && rd_stb && !fifo_push) |=> (q_count == '0 && !q_ovf)); // R3

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_push && !wr_ok) |=> q_ovf); // R4

    AST_RPT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_push |-> (rpt_en && key_held && !evt_valid)); // R6
endmodule

bind key_event_queue keyq_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .q_count  (q_count),
    .q_ovf    (q_ovf),
    .rd_data  (rd_data),
    .rd_stb   (rd_stb),
    .fifo_push(fifo_push),
    .wr_ok    (wr_ok),
    .rpt_push (rpt_push),
    .rpt_en   (rpt_en),
    .key_held (key_held),
    .evt_valid(evt_valid)
);

// File: tb/key_event_queue_tb.sv
module key_event_queue_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_valid = 1'b0;
    logic [5:0] evt_key = '0;
    logic       evt_release = 1'b0;
    logic       rel_en = 1'b1;
    logic       db_tick = 1'b0;
    logic       key_held = 1'b0;
    logic       rpt_en = 1'b0;
    logic [3:0] rpt_delay_sel = '0;
    logic [2:0] rpt_rate_sel = '0;
    logic [4:0] irq_time_sel = '0;
    logic [2:0] irq_fill_sel = '0;
    logic       irq_clr_on_read = 1'b1;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    key_event_queue u_dut (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_key(evt_key),
        .evt_release(evt_release), .rel_en(rel_en), .db_tick(db_tick),
        .key_held(key_held), .rpt_en(rpt_en), .rpt_delay_sel(rpt_delay_sel),
        .rpt_rate_sel(rpt_rate_sel), .irq_time_sel(irq_time_sel),
        .irq_fill_sel(irq_fill_sel), .irq_clr_on_read(irq_clr_on_read),
        .rd_stb(rd_stb), .rd_data(rd_data), .irq_n(irq_n)
    );

    // {rel_en, release, key[5:0], expected byte}
    localparam logic [15:0] VEC [8] = '{
        16'h8000, 16'hC545, 16'h493F, 16'h2121,
        16'hBF3F, 16'hFE7E, 16'hEA6A, 16'h1111
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic push(input logic [5:0] k, input logic rel);
        evt_valid = 1'b1; evt_key = k; evt_release = rel;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            db_tick = 1'b1;
            @(negedge clk);
            db_tick = 1'b0;
        end
    endtask

    task automatic rd(output logic [7:0] b);
        b = rd_data;
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] exp);
        logic [7:0] b;
        rd(b);
        chk(req, b, exp);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset read byte", rd_data, 8'h3F);
        chk("R1 reset irq_n", {7'd0, irq_n}, 8'h01);
        rst_n = 1'b1;
        @(negedge clk);

        // table: one event then one read each
        for (int i = 0; i < 8; i++) begin
            rel_en = VEC[i][15];
            push(VEC[i][13:8], VEC[i][14]);
            rd_chk("R2/R5 vector read", VEC[i][7:0]);
        end
        rel_en = 1'b1;

        // more bit and order
        push(6'd3, 1'b0); push(6'd4, 1'b1); push(6'd5, 1'b0);
        rd_chk("R2 first of three", 8'h83);
        rd_chk("R2 second of three", 8'hC4);
        rd_chk("R2 last of three", 8'h05);

        // empty read changes nothing
        rd_chk("R3 empty read", 8'h3F);
        rd_chk("R3 second empty read", 8'h3F);
        push(6'd20, 1'b0);
        rd_chk("R3 next event after empty reads", 8'h14);

        // overflow
        for (int i = 0; i < 18; i++) push(6'(i), 1'b0);
        for (int i = 0; i < 16; i++) rd_chk("R4/R1 stored entry", 8'h80 | 8'(i));
        rd_chk("R4 overflow marker", 8'h7F);
        rd_chk("R4 empty after marker", 8'h3F);

        // autorepeat: first delay 8, interval 4
        rpt_en = 1'b1; key_held = 1'b1;
        push(6'd5, 1'b0);
        rd_chk("R2 held key press", 8'h05);
        ticks(7);
        chk("R6 no marker before delay", rd_data, 8'h3F);
        ticks(1);
        chk("R6 marker after delay", rd_data, 8'h3E);
        rd_chk("R6 read marker", 8'h3E);
        ticks(3);
        chk("R7 no marker before interval", rd_data, 8'h3F);
        ticks(1);
        chk("R7 marker after interval", rd_data, 8'h3E);
        ticks(4);
        chk("R7 marker with more", rd_data, 8'h7E);
        rd_chk("R7 first marker", 8'h7E);
        rd_chk("R7 second marker", 8'h3E);
        push(6'd9, 1'b0);
        rd_chk("R8 new press", 8'h09);
        ticks(4);
        chk("R8 restart not at interval", rd_data, 8'h3F);
        ticks(4);
        chk("R8 restart at first delay", rd_data, 8'h3E);
        rd_chk("R8 read marker", 8'h3E);
        ticks(3);
        key_held = 1'b0;
        @(negedge clk);
        key_held = 1'b1;
        ticks(3);
        chk("R8 held low resets", rd_data, 8'h3F);
        ticks(4);
        chk("R8 still below first delay", rd_data, 8'h3F);
        ticks(1);
        chk("R8 first delay after held low", rd_data, 8'h3E);
        rpt_en = 1'b0; key_held = 1'b0;
        rd_chk("R8 drain", 8'h3E);

        // timer interrupt, clear on read
        irq_clr_on_read = 1'b1; irq_time_sel = 5'd3;
        push(6'd1, 1'b0);
        ticks(2);
        chk("R9 irq not yet", {7'd0, irq_n}, 8'h01);
        ticks(1);
        chk("R9 timer irq", {7'd0, irq_n}, 8'h00);
        rd_chk("R11 read byte", 8'h01);
        chk("R11 cleared on read", {7'd0, irq_n}, 8'h01);
        irq_time_sel = 5'd0;
        push(6'd2, 1'b0);
        ticks(35);
        chk("R9 timer disabled", {7'd0, irq_n}, 8'h01);
        rd_chk("R9 drain", 8'h02);

        // fill interrupt threshold 4, clear when empty
        irq_clr_on_read = 1'b0; irq_fill_sel = 3'd1;
        push(6'd10, 1'b0); push(6'd11, 1'b0); push(6'd12, 1'b0);
        @(negedge clk);
        chk("R10 below threshold", {7'd0, irq_n}, 8'h01);
        push(6'd13, 1'b0);
        chk("R10 not same cycle", {7'd0, irq_n}, 8'h01);
        @(negedge clk);
        chk("R10 fill irq", {7'd0, irq_n}, 8'h00);
        rd_chk("R12 read one", 8'h8A);
        @(negedge clk);
        chk("R12 held while nonempty", {7'd0, irq_n}, 8'h00);
        rd_chk("R12 read", 8'h8B);
        rd_chk("R12 read", 8'h8C);
        rd_chk("R12 read last", 8'h0D);
        chk("R12 not cleared at drain edge", {7'd0, irq_n}, 8'h00);
        @(negedge clk);
        chk("R12 cleared after empty", {7'd0, irq_n}, 8'h01);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule